// File: doc/BRIEF.md
# Guarded Configuration Register Port

This block puts a small bank of byte-wide configuration registers for one peripheral function behind a two-address access port. Address 0 is the index port and address 1 is the data port. The host first selects a register by writing its number to the index port. It then reads or writes that register through the data port.

Access is guarded. After reset the port is closed. It opens only when a fixed unlock byte is written twice in succession to the index port. While it is open, a fixed lock byte written to the index port closes it again. The register bank holds the following:
- a read-only 16-bit identifier,
- a function selector and an enable,
- a two-byte I/O base address,
- interrupt and DMA request channel numbers,
- pin and power setup bytes,
- a software reset bit for the function.

Every register drives an output of its own, so the function behind the port can use the values directly.

Reads have no side effects. `bus_rdata` always shows the value at the address that `bus_addr` currently selects.

Top module: `cfg_gate_port`

## Requirements
- R1: After reset the port is closed. Every configuration output is zero, `func_reset` is 0, and `bus_rdata` reads 0xFF at both addresses.
- R2: Two successive index-port writes of UNLOCK_CODE (default 0x87) open the port (`port_open`=1). A single such write does not open it.
- R3: While the port is closed, an index-port write of any other byte discards a pending first unlock byte. Sending 0x87, 0x55, 0x87 leaves the port closed.
- R4: While the port is open, an index-port write of LOCK_CODE (default 0xAA) closes it.
- R5: While the port is closed, both addresses read 0xFF. Data-port writes change no register and no output.
- R6: While the port is open, an index-port write of any byte other than LOCK_CODE selects that register. A data-port write stores the value and drives the matching output. A data-port read returns the stored value. Index map:
  - 0x30 function select (8 bits)
  - 0x31 enable (bit 0)
  - 0x32 base high
  - 0x33 base low
  - 0x34 IRQ number (low 4 bits)
  - 0x35 DRQ number (low 3 bits)
  - 0x36 pin setup
  - 0x37 power
  - 0x38 software reset (bit 0)
  - Unused bits read as 0.
- R7: Index 0x3E reads the upper byte and index 0x3F the lower byte of CHIP_ID (default 0x7A31). Writes to them are ignored.
- R8: `io_base` is {base high, base low}, and bits 2:0 are always 0. The low 3 bits written to base low are dropped, so the register reads back with them cleared.
- R9: `func_reset` is 1 while bit 0 of the software reset register is 1. It returns to 0 when 0 is written there.
- R10: While the port is open, a read of the index port returns the selected index. A data read of an unmapped index returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address |
| port_open | output | 1 | Register access granted |
| func_sel | output | 8 | Function selector |
| func_en | output | 1 | Function enable |
| io_base | output | 16 | Function I/O base, 8-byte aligned |
| irq_num | output | IRQ_W | Interrupt line number |
| drq_num | output | DRQ_W | DMA request channel |
| pin_cfg | output | 8 | Pin setup byte |
| pwr_cfg | output | 8 | Power setup byte |
| func_reset | output | 1 | Holds the function in reset |

## Verification
Directed sequences cover the ordering cases of the guard:
- a lone unlock byte,
- a pair broken by a foreign byte,
- a clean pair,
- the lock byte.

Together these separate a counter that resets correctly from one that only counts matches. Writes made while closed, followed by an unlock and a readback, distinguish ignored writes from writes that were merely hidden. The identifier, alignment and software-reset cases pin down the special registers. A long seeded random mix then exercises every interaction between guard state and register traffic against a bench model:
- unlock and lock bytes,
- mapped and unmapped indices,
- data writes,
- reads at both addresses.

// File: rtl/cfg_gate_port.sv
module cfg_gate_port #(
  parameter logic [7:0]  UNLOCK_CODE = 8'h87,
  parameter logic [7:0]  LOCK_CODE   = 8'hAA,
  parameter logic [15:0] CHIP_ID     = 16'h7A31,
  parameter int          IRQ_W       = 4,
  parameter int          DRQ_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             port_open,
  output logic [7:0]       func_sel,
  output logic             func_en,
  output logic [15:0]      io_base,
  output logic [IRQ_W-1:0] irq_num,
  output logic [DRQ_W-1:0] drq_num,
  output logic [7:0]       pin_cfg,
  output logic [7:0]       pwr_cfg,
  output logic             func_reset
);

  localparam logic [7:0] IX_FSEL = 8'h30;
  localparam logic [7:0] IX_EN   = 8'h31;
  localparam logic [7:0] IX_BHI  = 8'h32;
  localparam logic [7:0] IX_BLO  = 8'h33;
  localparam logic [7:0] IX_IRQ  = 8'h34;
  localparam logic [7:0] IX_DRQ  = 8'h35;
  localparam logic [7:0] IX_PIN  = 8'h36;
  localparam logic [7:0] IX_PWR  = 8'h37;
  localparam logic [7:0] IX_SRST = 8'h38;
  localparam logic [7:0] IX_IDH  = 8'h3E;
  localparam logic [7:0] IX_IDL  = 8'h3F;

  logic       half_key;
  logic [7:0] sel_idx;
  logic [7:0] base_hi;
  logic [4:0] base_lo;
  logic [7:0] data_val;

  wire idx_wr = bus_wr && !bus_addr;
  wire dat_wr = bus_wr &&  bus_addr && port_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_open <= 1'b0;
      half_key  <= 1'b0;
      sel_idx   <= 8'h00;
    end else if (idx_wr) begin
      if (!port_open) begin
        half_key <= (bus_wdata == UNLOCK_CODE) && !half_key;
        if (bus_wdata == UNLOCK_CODE && half_key) port_open <= 1'b1;
      end else if (bus_wdata == LOCK_CODE) begin
        port_open <= 1'b0;
        half_key  <= 1'b0;
      end else begin
        sel_idx <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_sel   <= '0;
      func_en    <= 1'b0;
      base_hi    <= '0;
      base_lo    <= '0;
      irq_num    <= '0;
      drq_num    <= '0;
      pin_cfg    <= '0;
      pwr_cfg    <= '0;
      func_reset <= 1'b0;
    end else if (dat_wr) begin
      case (sel_idx)
        IX_FSEL: func_sel   <= bus_wdata;
        IX_EN:   func_en    <= bus_wdata[0];
        IX_BHI:  base_hi    <= bus_wdata;
        IX_BLO:  base_lo    <= bus_wdata[7:3];
        IX_IRQ:  irq_num    <= bus_wdata[IRQ_W-1:0];
        IX_DRQ:  drq_num    <= bus_wdata[DRQ_W-1:0];
        IX_PIN:  pin_cfg    <= bus_wdata;
        IX_PWR:  pwr_cfg    <= bus_wdata;
        IX_SRST: func_reset <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  assign io_base = {base_hi, base_lo, 3'b000};

  always_comb begin
    case (sel_idx)
      IX_FSEL: data_val = func_sel;
      IX_EN:   data_val = {7'd0, func_en};
      IX_BHI:  data_val = base_hi;
      IX_BLO:  data_val = {base_lo, 3'b000};
      IX_IRQ:  data_val = 8'(irq_num);
      IX_DRQ:  data_val = 8'(drq_num);
      IX_PIN:  data_val = pin_cfg;
      IX_PWR:  data_val = pwr_cfg;
      IX_SRST: data_val = {7'd0, func_reset};
      IX_IDH:  data_val = CHIP_ID[15:8];
      IX_IDL:  data_val = CHIP_ID[7:0];
      default: data_val = 8'h00;
    endcase
  end

  assign bus_rdata = !port_open ? 8'hFF : (bus_addr ? data_val : sel_idx);

  assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_open) |-> $past(idx_wr && bus_wdata == UNLOCK_CODE));

  assert_lock_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    port_open && idx_wr && bus_wdata == LOCK_CODE |=> !port_open);

  assert_closed_reads_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !port_open |-> bus_rdata == 8'hFF);

  assert_closed_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !port_open && bus_wr && bus_addr |=>
      $stable(func_sel) && $stable(io_base) && $stable(pin_cfg) && $stable(pwr_cfg) && $stable(func_reset));

  assert_base_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    io_base[2:0] == 3'b000);

  assert_broken_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !port_open && idx_wr && bus_wdata != UNLOCK_CODE |=> !port_open);

endmodule

// File: tb/cfg_gate_port_bench.sv
module cfg_gate_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic port_open, func_en, func_reset;
  logic [7:0] func_sel, pin_cfg, pwr_cfg;
  logic [15:0] io_base;
  logic [3:0] irq_num;
  logic [2:0] drq_num;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_gate_port u_cfg_gate_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_open(port_open),
    .func_sel(func_sel), .func_en(func_en), .io_base(io_base),
    .irq_num(irq_num), .drq_num(drq_num), .pin_cfg(pin_cfg),
    .pwr_cfg(pwr_cfg), .func_reset(func_reset));

  // model state
  bit m_open, m_half, m_en, m_rst;
  logic [7:0] m_idx, m_sel, m_bhi, m_blo, m_pin, m_pwr;
  logic [3:0] m_irq;
  logic [2:0] m_drq;

  function automatic logic [7:0] exp_data();
    if (!m_open) return 8'hFF;
    case (m_idx)
      8'h30: return m_sel;
      8'h31: return {7'd0, m_en};
      8'h32: return m_bhi;
      8'h33: return m_blo;
      8'h34: return {4'd0, m_irq};
      8'h35: return {5'd0, m_drq};
      8'h36: return m_pin;
      8'h37: return m_pwr;
      8'h38: return {7'd0, m_rst};
      8'h3E: return 8'h7A;
      8'h3F: return 8'h31;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_index();
    return m_open ? m_idx : 8'hFF;
  endfunction

  function automatic logic [63:0] exp_outs();
    return {m_open, m_sel, m_en, m_bhi, m_blo, m_irq, m_drq, m_pin, m_pwr, m_rst, 18'd0};
  endfunction

  function automatic logic [63:0] act_outs();
    return {port_open, func_sel, func_en, io_base, irq_num, drq_num, pin_cfg, pwr_cfg, func_reset, 18'd0};
  endfunction

  task automatic model_reset();
    m_open = 0; m_half = 0; m_en = 0; m_rst = 0; m_idx = 0; m_sel = 0;
    m_bhi = 0; m_blo = 0; m_pin = 0; m_pwr = 0; m_irq = 0; m_drq = 0;
  endtask

  task automatic model_write(input bit a, input logic [7:0] d);
    if (!a) begin
      if (!m_open) begin
        if (d == 8'h87 && m_half) begin m_open = 1; m_half = 0; end
        else m_half = (d == 8'h87);
      end else if (d == 8'hAA) begin m_open = 0; m_half = 0; end
      else m_idx = d;
    end else if (m_open) begin
      case (m_idx)
        8'h30: m_sel = d;
        8'h31: m_en = d[0];
        8'h32: m_bhi = d;
        8'h33: m_blo = {d[7:3], 3'b000};
        8'h34: m_irq = d[3:0];
        8'h35: m_drq = d[2:0];
        8'h36: m_pin = d;
        8'h37: m_pwr = d;
        8'h38: m_rst = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    model_write(a, d);
    @(negedge clk);
    check(tag, act_outs(), exp_outs());
  endtask

  task automatic rd(input bit a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    check(tag, {56'd0, bus_rdata}, {56'd0, a ? exp_data() : exp_index()});
  endtask

  task automatic rd_const(input bit a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    check(tag, {56'd0, bus_rdata}, {56'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    model_reset();
    r = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 outputs", act_outs(), 64'd0);
    rd_const(1'b0, 8'hFF, "R1 index read");
    rd_const(1'b1, 8'hFF, "R1 data read");
    // R2 single key
    wr(1'b0, 8'h87, "R2 single key");
    check("R2 still closed", {63'd0, port_open}, 64'd0);
    wr(1'b0, 8'h87, "R2 second key");
    check("R2 open", {63'd0, port_open}, 64'd1);
    // R4 lock
    wr(1'b0, 8'hAA, "R4 lock");
    check("R4 closed", {63'd0, port_open}, 64'd0);
    // R3 broken sequence
    wr(1'b0, 8'h87, "R3 key a");
    wr(1'b0, 8'h55, "R3 foreign");
    wr(1'b0, 8'h87, "R3 key b");
    check("R3 remains closed", {63'd0, port_open}, 64'd0);
    wr(1'b0, 8'h87, "R3 key c");
    check("R3 opens on pair", {63'd0, port_open}, 64'd1);
    // R6 register write/read
    wr(1'b0, 8'h30, "R6 select fsel");
    wr(1'b1, 8'hC3, "R6 write fsel");
    rd_const(1'b1, 8'hC3, "R6 read fsel");
    rd_const(1'b0, 8'h30, "R10 index readback");
    wr(1'b0, 8'h34, "R6 select irq");
    wr(1'b1, 8'hFB, "R6 write irq");
    rd_const(1'b1, 8'h0B, "R6 irq masked");
    // R5 closed writes ignored
    wr(1'b0, 8'hAA, "R5 lock");
    wr(1'b1, 8'h11, "R5 closed data write");
    rd_const(1'b1, 8'hFF, "R5 closed data read");
    wr(1'b0, 8'h87, "R5 key a");
    wr(1'b0, 8'h87, "R5 key b");
    rd_const(1'b1, 8'h0B, "R5 value kept");
    // R7 chip id
    wr(1'b0, 8'h3E, "R7 select idh");
    rd_const(1'b1, 8'h7A, "R7 id high");
    wr(1'b1, 8'h00, "R7 write idh");
    rd_const(1'b1, 8'h7A, "R7 id high kept");
    wr(1'b0, 8'h3F, "R7 select idl");
    rd_const(1'b1, 8'h31, "R7 id low");
    // R8 alignment
    wr(1'b0, 8'h32, "R8 select bhi");
    wr(1'b1, 8'h02, "R8 write bhi");
    wr(1'b0, 8'h33, "R8 select blo");
    wr(1'b1, 8'h4F, "R8 write blo");
    check("R8 io_base", {48'd0, io_base}, {48'd0, 16'h0248});
    rd_const(1'b1, 8'h48, "R8 blo readback");
    // R9 software reset
    wr(1'b0, 8'h38, "R9 select srst");
    wr(1'b1, 8'h01, "R9 assert");
    check("R9 held", {63'd0, func_reset}, 64'd1);
    wr(1'b1, 8'h00, "R9 release");
    check("R9 released", {63'd0, func_reset}, 64'd0);
    // R10 unmapped
    wr(1'b0, 8'h5C, "R10 select unmapped");
    rd_const(1'b1, 8'h00, "R10 unmapped read");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: v = 8'h87;
        1: v = 8'hAA;
        2: v = 8'h30 + 8'($urandom_range(0, 15));
        default: v = 8'($urandom);
      endcase
      if (op < 4) wr(1'b0, v, "R6 random index write");
      else if (op < 7) wr(1'b1, 8'($urandom), "R6 random data write");
      else if (op < 9) rd(1'b1, "R6 random data read");
      else rd(1'b0, "R10 random index read");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule